// File: doc/BRIEF.md
# Repeated-Word Coincidence Validator

This block sits behind a frame decoder that delivers 8-bit words, each marked by a one-cycle valid strobe. It accepts a word as genuine only after the same value has arrived several times in a row, which filters line glitches and contact bounce out of a repeating transmission. Each incoming word is compared with the word received just before it. A match raises a small coincidence counter, and a mismatch clears it. The incoming word always replaces the stored reference, whatever the comparison gives.

When the counter reaches the number of matches picked by a mode input (two or four), the confirmed word is loaded into an output shift register, provided the load-enable input is high. At the same time a synchronisation pulse of fixed length tells an external controller that fresh data is ready. The controller then clocks the word out serially, one bit per rising edge of its shift clock. The shift clock is sampled in the block's own clock domain.

Top module: `coinc_validator`

## Requirements
- R1: On each valid word, the counter goes up by one if the word equals the stored reference and clears to zero if it differs.
- R2: Every valid word overwrites the stored reference, so a later word is compared with the most recent word whatever the earlier comparison gave.
- R3: With `quad_mode_i`=0 a transfer needs two consecutive matches (three identical words in a row). With `quad_mode_i`=1 it needs four matches (five identical words).
- R4: A transfer loads the confirmed word into the output register. `sdo_o` shows bit 7 of the register, and each rising edge on `sclk_i` shifts the register one place toward bit 7 with a zero entering bit 0, so the word leaves most significant bit first.
- R5: While `load_en_i` is low, no transfer takes place: the output register and `sync_o` are not affected by incoming words.
- R6: `sync_o` goes high on the cycle after the transfer and stays high for exactly 16 clock cycles. A new transfer during the pulse restarts the 16 cycles.
- R7: The counter is zero when a transfer completes, so the next transfer again needs the full number of matches.
- R8: A matching word that arrives while `load_en_i` is low holds the counter at its threshold. The next matching word that arrives with `load_en_i` high transfers at once.
- R9: While `rst_n` is low, the reference, the counter and the output register are cleared and `sync_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 8 | Word from the frame decoder |
| word_vld_i | input | 1 | One-cycle strobe marking `word_i` as new |
| quad_mode_i | input | 1 | 0: two matches required, 1: four matches required |
| load_en_i | input | 1 | High allows a transfer into the output register |
| sclk_i | input | 1 | Serial shift clock from the reader, sampled on `clk` |
| sdo_o | output | 1 | Serial data out, bit 7 of the output register |
| sync_o | output | 1 | 16-cycle data-ready pulse |

## Verification
The counter and the reference update on the clock edge that samples the strobe. A transfer loads the output register on that same edge, and `sync_o` rises with it, so all of these can be seen one cycle after the strobe. A shift clock edge is seen on the first clock edge after `sclk_i` goes high, and the new `sdo_o` follows on that edge. The bench drives inputs on falling clock edges and samples on the next falling edge, so each result is read half a cycle after the edge that produced it. The pulse width is measured by counting falling edges with `sync_o` high until it drops, and must come to 16.

// File: rtl/cv_pkg.sv
package cv_pkg;

  // number of matches required for a transfer in the given mode
  function automatic int cv_threshold(input logic quad, input int lo_hits, input int hi_hits);
    return quad ? hi_hits : lo_hits;
  endfunction

  // next coincidence count: match advances, saturating at the threshold; mismatch clears
  function automatic int cv_next_count(input int cnt, input logic match, input int thr);
    if (!match)      return 0;
    else if (cnt >= thr) return thr;
    else             return cnt + 1;
  endfunction

endpackage

// File: rtl/cv_compare.sv
module cv_compare #(
  parameter int WORD_W  = 8,
  parameter int LO_HITS = 2,
  parameter int HI_HITS = 4,
  localparam int CNT_W  = $clog2(HI_HITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              quad_mode_i,
  input  logic              load_en_i,
  output logic              match_o,
  output logic              xfer_o,
  output logic [CNT_W-1:0]  thr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] ref_o
);
  import cv_pkg::*;

  logic [WORD_W-1:0] ref_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  thr;

  always_comb begin
    thr     = CNT_W'(cv_threshold(quad_mode_i, LO_HITS, HI_HITS));
    match_o = (word_i == ref_q);
    cnt_nxt = CNT_W'(cv_next_count(int'(cnt_q), match_o, int'(thr)));
    xfer_o  = word_vld_i && load_en_i && (cnt_nxt == thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= '0;
      cnt_q <= '0;
    end else if (word_vld_i) begin
      ref_q <= word_i;
      cnt_q <= xfer_o ? '0 : cnt_nxt;
    end
  end

  assign thr_o = thr;
  assign cnt_o = cnt_q;
  assign ref_o = ref_q;
endmodule

// File: rtl/cv_outreg.sv
module cv_outreg #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              sclk_i,
  output logic              shift_o,
  output logic              sdo_o,
  output logic [WORD_W-1:0] shreg_o
);
  logic              sclk_q;
  logic [WORD_W-1:0] shreg_q;

  assign shift_o = sclk_i && !sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      shreg_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (load_i)       shreg_q <= data_i;
      else if (shift_o) shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo_o   = shreg_q[WORD_W-1];
  assign shreg_o = shreg_q;
endmodule

// File: rtl/cv_syncgen.sv
module cv_syncgen #(
  parameter int SYNC_LEN = 16,
  localparam int TMR_W   = $clog2(SYNC_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic sync_o
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            tmr_q <= '0;
    else if (trig_i)       tmr_q <= TMR_W'(SYNC_LEN);
    else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
  end

  assign sync_o = (tmr_q != '0);
endmodule

// File: rtl/coinc_validator.sv
module coinc_validator #(
  parameter int WORD_W   = 8,
  parameter int LO_HITS  = 2,
  parameter int HI_HITS  = 4,
  parameter int SYNC_LEN = 16,
  localparam int CNT_W   = $clog2(HI_HITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              quad_mode_i,
  input  logic              load_en_i,
  input  logic              sclk_i,
  output logic              sdo_o,
  output logic              sync_o
);
  // named internal events for the checker
  logic              match_w;
  logic              xfer_w;
  logic              shift_w;
  logic [CNT_W-1:0]  thr_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [WORD_W-1:0] ref_w;
  logic [WORD_W-1:0] shreg_w;

  cv_compare #(.WORD_W(WORD_W), .LO_HITS(LO_HITS), .HI_HITS(HI_HITS)) u_cmp (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_vld_i(word_vld_i),
    .quad_mode_i(quad_mode_i), .load_en_i(load_en_i),
    .match_o(match_w), .xfer_o(xfer_w), .thr_o(thr_w), .cnt_o(cnt_w), .ref_o(ref_w)
  );

  cv_outreg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load_i(xfer_w), .data_i(word_i), .sclk_i(sclk_i),
    .shift_o(shift_w), .sdo_o(sdo_o), .shreg_o(shreg_w)
  );

  cv_syncgen #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .trig_i(xfer_w), .sync_o(sync_o)
  );
endmodule

// File: rtl/cv_checker.sv
module cv_checker #(
  parameter int WORD_W   = 8,
  parameter int HI_HITS  = 4,
  parameter int SYNC_LEN = 16,
  localparam int CNT_W   = $clog2(HI_HITS + 1),
  localparam int RUN_W   = $clog2(SYNC_LEN + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_i,
  input logic              word_vld_i,
  input logic              load_en_i,
  input logic              match_w,
  input logic              xfer_w,
  input logic              shift_w,
  input logic [CNT_W-1:0]  thr_w,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [WORD_W-1:0] ref_w,
  input logic [WORD_W-1:0] shreg_w,
  input logic              sync_o
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (xfer_w) run_q <= '0;
    else if (sync_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R1
  mismatch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && !match_w) |=> (cnt_w == '0));

  // R1
  match_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && match_w && !xfer_w && (cnt_w < thr_w)) |=> (cnt_w == $past(cnt_w) + 1'b1));

  // R2
  ref_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_i |=> (ref_w == $past(word_i)));

  // R3
  threshold_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_w |-> (match_w && (cnt_w + 1'b1 >= thr_w)));

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_w |=> (shreg_w == $past(word_i)));

  // R5
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en_i && !shift_w) |=> $stable(shreg_w));

  // R6
  sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_w |=> sync_o);

  // R6
  sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_o) |-> (run_q == RUN_W'(SYNC_LEN)));

  // R7
  count_zero_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> (cnt_w == '0));

  // R8
  hold_at_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && match_w && !load_en_i && (cnt_w == thr_w)) |=> (cnt_w == $past(thr_w)));
endmodule

bind coinc_validator cv_checker #(.WORD_W(WORD_W), .HI_HITS(HI_HITS), .SYNC_LEN(SYNC_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_vld_i(word_vld_i), .load_en_i(load_en_i),
  .match_w(match_w), .xfer_w(xfer_w), .shift_w(shift_w), .thr_w(thr_w), .cnt_w(cnt_w),
  .ref_w(ref_w), .shreg_w(shreg_w), .sync_o(sync_o)
);

// File: tb/sim_coinc_validator.sv
module sim_coinc_validator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] word_i = '0;
  logic       word_vld_i = 1'b0;
  logic       quad_mode_i = 1'b0;
  logic       load_en_i = 1'b1;
  logic       sclk_i = 1'b0;
  logic       sdo_o;
  logic       sync_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  coinc_validator u0 (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_vld_i(word_vld_i),
    .quad_mode_i(quad_mode_i), .load_en_i(load_en_i), .sclk_i(sclk_i),
    .sdo_o(sdo_o), .sync_o(sync_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] w);
    @(negedge clk);
    word_i = w;
    word_vld_i = 1'b1;
    @(negedge clk);
    word_vld_i = 1'b0;
  endtask

  task automatic read_word(output logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      w = {w[6:0], sdo_o};
      sclk_i = 1'b1;
      @(negedge clk);
      sclk_i = 1'b0;
    end
  endtask

  task automatic wait_sync_low();
    while (sync_o) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] w;
    check("R9 sync after reset", sync_o, 0);
    check("R9 sdo after reset", sdo_o, 0);
    read_word(w);
    check("R9 output register after reset", w, 8'h00);
  endtask

  task automatic t_double();
    logic [7:0] w;
    int width;
    quad_mode_i = 1'b0; load_en_i = 1'b1;
    send(8'hA5); send(8'hA5);
    check("R3 no sync after one match", sync_o, 0);
    send(8'hA5);
    check("R3 sync after two matches", sync_o, 1);
    width = 0;
    while (sync_o) begin width++; @(negedge clk); end
    check("R6 sync width", width, 16);
    read_word(w);
    check("R4 serial word double mode", w, 8'hA5);
  endtask

  task automatic t_quad();
    logic [7:0] w;
    quad_mode_i = 1'b1;
    send(8'h3C); send(8'h3C); send(8'h3C); send(8'h3C);
    check("R3 no sync after three matches", sync_o, 0);
    send(8'h3C);
    check("R3 sync after four matches", sync_o, 1);
    read_word(w);
    check("R4 serial word quad mode", w, 8'h3C);
    wait_sync_low();
  endtask

  task automatic t_mismatch();
    logic [7:0] w;
    quad_mode_i = 1'b0;
    send(8'h5A); send(8'h5A); send(8'h66); send(8'h5A); send(8'h5A);
    check("R1 R2 mismatch cleared count", sync_o, 0);
    send(8'h5A);
    check("R1 sync after two fresh matches", sync_o, 1);
    read_word(w);
    check("R4 serial word after mismatch", w, 8'h5A);
    wait_sync_low();
  endtask

  task automatic t_blocked();
    logic [7:0] w;
    load_en_i = 1'b0;
    send(8'h81); send(8'h81); send(8'h81); send(8'h81);
    check("R5 no sync while blocked", sync_o, 0);
    check("R5 output register untouched", sdo_o, 0);
    load_en_i = 1'b1;
    send(8'h81);
    check("R8 transfer on first enabled match", sync_o, 1);
    wait_sync_low();
    send(8'h81);
    check("R7 count restarted after transfer", sync_o, 0);
    send(8'h81);
    check("R7 transfer after full count again", sync_o, 1);
    read_word(w);
    check("R4 serial word after release", w, 8'h81);
  endtask

  task automatic t_retrigger();
    int width;
    send(8'h42); send(8'h42); send(8'h42);
    repeat (5) @(negedge clk);
    send(8'h42); send(8'h42);
    width = 0;
    while (sync_o) begin width++; @(negedge clk); end
    check("R6 retriggered pulse restarts", width, 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_double();
    t_quad();
    t_mismatch();
    t_blocked();
    t_retrigger();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule